// File: doc/BRIEF.md
# Micro-ID Segment List Compressor

This block shortens a list of 128-bit segment identifiers. Each identifier whose top bits agree with a configured shared prefix gives up only its final 16 bits, a micro-ID. Micro-IDs are packed behind one copy of the 16-bit prefix into 128-bit containers, seven per container. A container that fills is sent and a new one begins. Compression stops at the first identifier that does not carry the prefix. That identifier and every one after it in the list leave unchanged.

Identifiers arrive on a valid/ready stream with a last marker that closes each list. Words leave on a valid/ready stream that carries the same kind of marker, a flag telling a packed container from a raw identifier, and, on the final beat, the number of bytes the list shrank by. That byte count lets a later stage patch the packet length field. The prefix and the number of prefix bits that must agree are plain configuration pins, held steady while a list is in flight.

Back-pressure: the output holds one registered word. While that word waits (out_valid high, out_ready low), everything on the output stays frozen and in_ready is low. An identifier that closes a partly filled container is not taken in the cycle the container is sent, so in_ready also depends on in_sid for that one case.

Top module: `usid_compressor`

## Requirements
- R1: After reset, out_valid is 0, and in_ready is 1 while the output is empty.
- R2: An identifier matches when the top cfg_plen bits of its upper 16 bits equal the same bits of cfg_prefix. A cfg_plen of 0 matches every identifier, and values above 16 act as 16.
- R3: A packed container has cfg_prefix in bits [127:112]. Micro-ID k (k = 0..6, in arrival order) sits in bits [111-16k -: 16] and equals bits [15:0] of its identifier. out_packed is 1 on such a word.
- R4: Once a container holds seven micro-IDs it is emitted, and the next matching identifier starts a new container at slot 0.
- R5: A container emitted with fewer than seven micro-IDs has all of its unused slots at zero.
- R6: The first non-matching identifier ends compression. Any partly filled container is emitted first. Then that identifier and every later one in the list are emitted unchanged and in order, with out_packed at 0.
- R7: When a list ends, a pending container is emitted. out_last is 1 on the final output word of each list and only there.
- R8: On the beat with out_last, out_saved equals 16 × (identifiers in) − 16 × (words out) for that list. On all other beats it is 0.
- R9: While out_valid is 1 and out_ready is 0, out_data, out_last, out_packed and out_saved hold their values and in_ready is 0.
- R10: Each new list starts in compressing mode with an empty container, whatever the previous list did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prefix | input | 16 | Shared prefix |
| cfg_plen | input | 5 | Number of prefix bits compared, counted from the top |
| in_valid | input | 1 | Input identifier valid |
| in_ready | output | 1 | Block accepts the input identifier |
| in_sid | input | 128 | Segment identifier |
| in_last | input | 1 | Identifier closes the list |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 128 | Packed container or raw identifier |
| out_last | output | 1 | Final word of the list |
| out_packed | output | 1 | Word is a packed container |
| out_saved | output | 12 | Bytes saved on the list, valid with out_last |

## Verification
Every output word shows up one clock after the edge that loads it. That edge is the one that accepts the completing identifier, or the flush edge that sends a partial container ahead of a non-matching identifier. A matching identifier that does not complete a container produces no word at all. The bench therefore does not expect fixed latencies. It records each word at the moment of its output handshake, sampled in the second half of the clock period, and compares the recorded sequence against a list built from the requirements. In the same sample window it checks that stalled words stay frozen and that in_ready is low during a stall, and it checks the saved-byte count only on the beat that carries out_last.

// File: rtl/usid_pkg.sv
package usid_pkg;
  // Operating mode while a list streams through
  typedef enum logic {
    MODE_PACK = 1'b0,   // matching identifiers are folded into containers
    MODE_PASS = 1'b1    // prefix run ended; identifiers go out raw
  } usid_mode_e;
endpackage

// File: rtl/usid_prefix_match.sv
module usid_prefix_match #(
  parameter int UID_W  = 16,
  parameter int PLEN_W = $clog2(UID_W) + 1
) (
  input  logic [UID_W-1:0]  sid_top,
  input  logic [UID_W-1:0]  cfg_prefix,
  input  logic [PLEN_W-1:0] cfg_plen,
  output logic              hit
);
  logic [UID_W-1:0] mask;

  // Mask covers the top cfg_plen bits; lengths beyond UID_W saturate
  always_comb begin
    for (int b = 0; b < UID_W; b++) begin
      mask[UID_W-1-b] = (b < int'(cfg_plen));
    end
  end

  assign hit = ((sid_top ^ cfg_prefix) & mask) == '0;
endmodule

// File: rtl/usid_pack_acc.sv
module usid_pack_acc #(
  parameter int SID_W = 128,
  parameter int UID_W = 16,
  parameter int SLOTS = SID_W / UID_W - 1,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [UID_W-1:0] uid,
  input  logic [UID_W-1:0] prefix,
  output logic [SID_W-1:0] cur_word,
  output logic [SID_W-1:0] push_word,
  output logic [CW-1:0]    cnt
);
  logic [UID_W-1:0] slot_q [SLOTS];
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      for (int k = 0; k < SLOTS; k++) slot_q[k] <= '0;
    end else if (push) begin
      cnt_q <= cnt_q + CW'(1);
      for (int k = 0; k < SLOTS; k++) begin
        if (k == int'(cnt_q)) slot_q[k] <= uid;
      end
    end
  end

  assign cur_word [SID_W-1 -: UID_W] = prefix;
  assign push_word[SID_W-1 -: UID_W] = prefix;

  // Slot k sits right below the prefix, earlier micro-IDs higher
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam int LO = SID_W - UID_W * (k + 2);
    assign cur_word [LO +: UID_W] = slot_q[k];
    assign push_word[LO +: UID_W] = (k == int'(cnt_q)) ? uid : slot_q[k];
  end

  assign cnt = cnt_q;

  // R4
  full_never_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < SLOTS);
endmodule

// File: rtl/usid_out_stage.sv
module usid_out_stage #(
  parameter int DW = 128,
  parameter int SW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d_data,
  input  logic          d_last,
  input  logic          d_packed,
  input  logic [SW-1:0] d_saved,
  output logic          can_load,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          out_packed,
  output logic [SW-1:0] out_saved
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_last   <= 1'b0;
      out_packed <= 1'b0;
      out_saved  <= '0;
    end else if (load && can_load) begin
      out_valid  <= 1'b1;
      out_data   <= d_data;
      out_last   <= d_last;
      out_packed <= d_packed;
      out_saved  <= d_saved;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)
                                   && $stable(out_packed) && $stable(out_saved)));
endmodule

// File: rtl/usid_compressor.sv
module usid_compressor
  import usid_pkg::*;
#(
  parameter int SID_W  = 128,
  parameter int UID_W  = 16,
  parameter int CNT_W  = 8,
  parameter int PLEN_W = $clog2(UID_W) + 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [UID_W-1:0]                     cfg_prefix,
  input  logic [PLEN_W-1:0]                    cfg_plen,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [SID_W-1:0]                     in_sid,
  input  logic                                 in_last,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [SID_W-1:0]                     out_data,
  output logic                                 out_last,
  output logic                                 out_packed,
  output logic [CNT_W+$clog2(SID_W/8)-1:0]     out_saved
);
  localparam int SLOTS = SID_W / UID_W - 1;
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int SH    = $clog2(SID_W / 8);
  localparam int SAV_W = CNT_W + SH;

  usid_mode_e       mode_q, mode_d;
  logic [CNT_W-1:0] in_cnt_q, out_cnt_q;
  logic             hit, can_load;
  logic             consume, emit, acc_push, acc_clr;
  logic [SID_W-1:0] cur_word, push_word, e_data;
  logic             e_last, e_packed;
  logic [SAV_W-1:0] e_saved;
  logic [CW-1:0]    acc_cnt;
  logic             flush_first;

  usid_prefix_match #(.UID_W(UID_W), .PLEN_W(PLEN_W)) u_match (
    .sid_top    (in_sid[SID_W-1 -: UID_W]),
    .cfg_prefix (cfg_prefix),
    .cfg_plen   (cfg_plen),
    .hit        (hit)
  );

  usid_pack_acc #(.SID_W(SID_W), .UID_W(UID_W), .SLOTS(SLOTS), .CW(CW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (acc_clr),
    .push      (acc_push),
    .uid       (in_sid[UID_W-1:0]),
    .prefix    (cfg_prefix),
    .cur_word  (cur_word),
    .push_word (push_word),
    .cnt       (acc_cnt)
  );

  // A non-matching identifier behind a partial container waits one beat
  assign flush_first = (mode_q == MODE_PACK) && !hit && (acc_cnt != '0);
  assign in_ready    = can_load && !flush_first;

  always_comb begin
    consume  = 1'b0;
    emit     = 1'b0;
    acc_push = 1'b0;
    acc_clr  = 1'b0;
    e_data   = in_sid;
    e_last   = 1'b0;
    e_packed = 1'b0;
    mode_d   = mode_q;
    if (in_valid && can_load) begin
      if (mode_q == MODE_PACK && hit) begin
        consume  = 1'b1;
        acc_push = 1'b1;
        if (acc_cnt == CW'(SLOTS - 1) || in_last) begin
          emit     = 1'b1;
          acc_clr  = 1'b1;
          e_data   = push_word;
          e_packed = 1'b1;
          e_last   = in_last;
        end
      end else if (flush_first) begin
        emit     = 1'b1;
        acc_clr  = 1'b1;
        e_data   = cur_word;
        e_packed = 1'b1;
        mode_d   = MODE_PASS;
      end else begin
        consume = 1'b1;
        emit    = 1'b1;
        e_last  = in_last;
        mode_d  = in_last ? MODE_PACK : MODE_PASS;
      end
    end
  end

  // Words out never exceed identifiers in, so the difference stays positive
  assign e_saved = (consume && in_last) ? {in_cnt_q - out_cnt_q, {SH{1'b0}}} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_PACK;
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
    end else if (consume && in_last) begin
      mode_q    <= MODE_PACK;
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
    end else begin
      mode_q    <= mode_d;
      if (consume) in_cnt_q  <= in_cnt_q + CNT_W'(1);
      if (emit)    out_cnt_q <= out_cnt_q + CNT_W'(1);
    end
  end

  usid_out_stage #(.DW(SID_W), .SW(SAV_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (emit),
    .d_data     (e_data),
    .d_last     (e_last),
    .d_packed   (e_packed),
    .d_saved    (e_saved),
    .can_load   (can_load),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_packed (out_packed),
    .out_saved  (out_saved)
  );

  // R6
  pass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PASS && in_valid && in_ready)
      |=> (out_valid && !out_packed && out_data == $past(in_sid)));

  // R3
  packed_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_packed) |-> (out_data[SID_W-1 -: UID_W] == cfg_prefix));

  // R10
  fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last)
      |=> (mode_q == MODE_PACK && in_cnt_q == '0 && out_cnt_q == '0 && acc_cnt == '0));
endmodule

// File: tb/tb_usid_compressor.sv
`timescale 1ns/1ps
module tb_usid_compressor;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  cfg_prefix = 16'h2001;
  logic [4:0]   cfg_plen = 5'd16;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_sid = '0;
  logic         in_last = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_last;
  logic         out_packed;
  logic [11:0]  out_saved;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  usid_compressor dut (
    .clk(clk), .rst_n(rst_n), .cfg_prefix(cfg_prefix), .cfg_plen(cfg_plen),
    .in_valid(in_valid), .in_ready(in_ready), .in_sid(in_sid), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_packed(out_packed), .out_saved(out_saved)
  );

  // {identifiers, generated-matching count, prefix length, stall}
  localparam logic [21:0] VECS [11] = '{
    {8'd3,  8'd3,  5'd16, 1'b0},
    {8'd7,  8'd7,  5'd16, 1'b0},
    {8'd8,  8'd8,  5'd16, 1'b1},
    {8'd15, 8'd15, 5'd16, 1'b0},
    {8'd5,  8'd2,  5'd16, 1'b1},
    {8'd4,  8'd0,  5'd16, 1'b0},
    {8'd9,  8'd7,  5'd16, 1'b1},
    {8'd6,  8'd6,  5'd8,  1'b0},
    {8'd1,  8'd1,  5'd16, 1'b0},
    {8'd5,  8'd3,  5'd20, 1'b1},
    {8'd3,  8'd1,  5'd0,  1'b0}
  };

  task automatic check(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic run_list(input int n_in, input int n_gen, input int plen, input bit stall, input int id);
    logic [127:0] sids [32];
    logic [127:0] exp_d [$];
    bit           exp_p [$];
    logic [127:0] rc_d [$];
    bit           rc_p [$];
    bit           rc_l [$];
    logic [11:0]  rc_s [$];
    logic [15:0]  mask;
    logic [15:0]  sl [7];
    logic [127:0] w;
    logic [15:0]  top;
    int           n;
    bit           pack;
    bit           hit;
    int           last_idx;

    cfg_plen = 5'(plen);
    for (int i = 0; i < n_in; i++) begin
      if (i < n_gen) top = (plen == 8) ? {cfg_prefix[15:8], 8'h3C ^ 8'(i)} : cfg_prefix;
      else           top = cfg_prefix ^ 16'h8000;
      sids[i] = {top, 32'hDEAD0000 | 32'(i), 64'h0123_4567_89AB_CDEF, 16'h1000 + 16'(id * 256 + i)};
    end

    // Expected output sequence from the requirements
    mask = 16'h0;
    for (int b = 0; b < 16; b++) if (b < plen) mask[15-b] = 1'b1;
    pack = 1'b1;
    n = 0;
    for (int i = 0; i < n_in; i++) begin
      hit = ((sids[i][127:112] ^ cfg_prefix) & mask) == 16'h0;
      if (pack && hit) begin
        sl[n] = sids[i][15:0];
        n++;
        if (n == 7 || i == n_in - 1) begin
          w = '0; w[127:112] = cfg_prefix;
          for (int k = 0; k < n; k++) w[96 - 16*k +: 16] = sl[k];
          exp_d.push_back(w); exp_p.push_back(1'b1);
          n = 0;
        end
      end else begin
        if (pack && n > 0) begin
          w = '0; w[127:112] = cfg_prefix;
          for (int k = 0; k < n; k++) w[96 - 16*k +: 16] = sl[k];
          exp_d.push_back(w); exp_p.push_back(1'b1);
          n = 0;
        end
        pack = 1'b0;
        exp_d.push_back(sids[i]); exp_p.push_back(1'b0);
      end
    end

    fork
      begin : drive
        for (int i = 0; i < n_in; i++) begin
          @(negedge clk);
          in_valid = 1'b1;
          in_sid   = sids[i];
          in_last  = (i == n_in - 1);
          #1;
          while (!in_ready) begin
            @(negedge clk);
            #1;
          end
          @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      begin : collect
        int cyc = 0;
        bit stalled = 1'b0;
        logic [127:0] held = '0;
        bit done = 1'b0;
        while (!done) begin
          @(negedge clk);
          out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
          cyc++;
          #2;
          if (stalled && out_valid)
            check(out_data == held, "R9 stalled word changed", out_data, held);
          if (out_valid && !out_ready)
            check(in_ready == 1'b0, "R9 in_ready during stall", 128'(in_ready), 128'd0);
          stalled = out_valid && !out_ready;
          held = out_data;
          if (out_valid && out_ready) begin
            rc_d.push_back(out_data); rc_p.push_back(out_packed);
            rc_l.push_back(out_last); rc_s.push_back(out_saved);
            if (out_last) done = 1'b1;
          end
        end
        out_ready = 1'b1;
      end
    join

    check(rc_d.size() == exp_d.size(), "R7 R10 word count per list", 128'(rc_d.size()), 128'(exp_d.size()));
    for (int i = 0; i < rc_d.size() && i < exp_d.size(); i++) begin
      if (exp_p[i])
        check(rc_d[i] == exp_d[i] && rc_p[i], "R2 R3 R4 R5 packed container", rc_d[i], exp_d[i]);
      else
        check(rc_d[i] == exp_d[i] && !rc_p[i], "R6 raw identifier", rc_d[i], exp_d[i]);
    end
    last_idx = rc_d.size() - 1;
    for (int i = 0; i < rc_d.size(); i++) begin
      check(rc_l[i] == (i == last_idx), "R7 out_last position", 128'(rc_l[i]), 128'(i == last_idx));
      if (i == last_idx)
        check(rc_s[i] == 12'(16 * (n_in - exp_d.size())), "R8 saved bytes on last", 128'(rc_s[i]),
              128'(16 * (n_in - exp_d.size())));
      else
        check(rc_s[i] == 12'd0, "R8 saved bytes off last", 128'(rc_s[i]), 128'd0);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual list not finished, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid in reset", 128'(out_valid), 128'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 128'(in_ready), 128'd1);

    // Table-driven lists
    for (int v = 0; v < 11; v++) begin
      run_list(int'(VECS[v][21:14]), int'(VECS[v][13:6]), int'(VECS[v][5:1]), VECS[v][0], v);
    end

    // Directed: a different prefix across back-to-back lists, fresh start R10
    cfg_prefix = 16'hFC00;
    run_list(10, 10, 16, 1'b1, 12);
    run_list(2, 0, 16, 1'b0, 13);
    run_list(14, 14, 16, 1'b1, 14);
    // R2: prefix length 1 matches on the top bit only
    run_list(4, 4, 1, 1'b0, 15);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule